// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier with Split Result Halves

This block multiplies two 32-bit operands over a fixed number of clock cycles using a single 32-bit adder. A 64-bit working register holds both the growing partial product and the multiplier. The multiplier starts in the low half of that register and gives up one bit per step. Each step adds the multiplicand into the high half when the bit leaving the register is set, then shifts the whole register right by one place.

A caller raises a one-cycle start pulse while the block is idle. It presents the operands and a mode bit that selects signed (two's complement) or unsigned interpretation. While the work runs, `busy` stays high. When the product is complete, `done` pulses for a single cycle. From that cycle on, the upper and lower 32 bits of the product are available on two separate read ports. These stay unchanged until the next product completes.

Signed operation turns both operands into magnitudes at load time. It multiplies the magnitudes as unsigned values and negates the 64-bit result during the final cycle when the operand signs differ.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both `hiOut` and `loOut` read 0.
- R2: A start pulse sampled while `busy` is 0 is accepted, and `busy` reads 1 in the cycle after that clock edge.
- R3: `busy` stays high for exactly 33 cycles after an accepted start. The 33rd clock edge after the accepting edge lowers `busy` and raises `done`. `done` is high for exactly one cycle and is never high together with `busy`.
- R4: With `signedMode` = 0, the 64-bit result equals the unsigned product of the two operands.
- R5: With `signedMode` = 1, the 64-bit result equals the two's complement product of the two operands taken as signed values.
- R6: `hiOut` carries bits 63..32 of the result and `loOut` carries bits 31..0.
- R7: A start pulse sampled while `busy` is 1 is ignored. The running product, its completion time and its operands are unaffected, and no extra `done` follows.
- R8: `hiOut` and `loOut` keep their previous values at every clock edge except the one that raises `done`.
- R9: Zero operands give a zero result in both modes. In signed mode, 0x80000000 as either or both operands gives the exact 64-bit product (for example, 0x80000000 × 0x80000000 = 0x4000000000000000).
- R10: A start pulse presented during the cycle in which `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request a new multiplication |
| signedMode | input | 1 | 1 = signed operands, 0 = unsigned |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion strobe |
| hiOut | output | 32 | Upper half of the last completed product |
| loOut | output | 32 | Lower half of the last completed product |

## Verification
Two events can coincide in one cycle: the completion strobe, together with the update of the result halves, and the acceptance of the next start. The bench waits for `done` and raises the next start in that same cycle. The scoreboard then checks three things: the first product's halves are correct when `done` shows, those halves stay put for the whole second run, and the second `done` arrives exactly on schedule with its own product. Start pulses injected in mid-run must leave both the timing and the values of the queued results untouched.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } mulCtrl_t;
endpackage

// File: rtl/shift_add_ctrl.sv
module shift_add_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam int LEN_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] stepCnt;
  logic doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: if (startPulse) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIN;
        end
        ST_FIN: begin
          state   <= ST_IDLE;
          doneReg <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && startPulse;
    ctrl.step   = (state == ST_RUN);
    ctrl.commit = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  // Independent length count of the busy window, used only by the check below.
  logic [LEN_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (ctrl.load) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> busyLen == LEN_W'(WIDTH + 1));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && state == ST_RUN) |=> (state != ST_IDLE) && !done);
endmodule

// File: rtl/shift_add_dp.sv
module shift_add_dp
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulCtrl_t         ctrl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand;
  logic [PW-1:0]    prodReg;
  logic             negRes;
  logic [WIDTH-1:0] hiReg, loReg;

  logic             aNeg, bNeg;
  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH:0]   sumWide;
  logic [PW-1:0]    finalProd;

  always_comb begin
    aNeg = signedMode && opA[WIDTH-1];
    bNeg = signedMode && opB[WIDTH-1];
    magA = aNeg ? (~opA + 1'b1) : opA;
    magB = bNeg ? (~opB + 1'b1) : opB;
    sumWide = {1'b0, prodReg[PW-1:WIDTH]} +
              {1'b0, (prodReg[0] ? mcand : {WIDTH{1'b0}})};
    finalProd = negRes ? (~prodReg + 1'b1) : prodReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand   <= '0;
      prodReg <= '0;
      negRes  <= 1'b0;
      hiReg   <= '0;
      loReg   <= '0;
    end else begin
      if (ctrl.load) begin
        mcand   <= magA;
        prodReg <= {{WIDTH{1'b0}}, magB};
        negRes  <= aNeg ^ bNeg;
      end else if (ctrl.step) begin
        prodReg <= {sumWide, prodReg[WIDTH-1:1]};
      end
      if (ctrl.commit) begin
        hiReg <= finalProd[PW-1:WIDTH];
        loReg <= finalProd[WIDTH-1:0];
      end
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commit |=> $stable(hiReg) && $stable(loReg));

  assert_shift_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> prodReg[WIDTH-2:0] == $past(prodReg[WIDTH-1:1]));

  assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> $stable(negRes) && $stable(mcand));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  mulCtrl_t ctrl;

  shift_add_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  shift_add_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .signedMode(signedMode),
    .opA(opA), .opB(opB), .hiOut(hiOut), .loOut(loOut)
  );

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> busy);
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic signedMode = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic busy, done;
  logic [31:0] hiOut, loOut;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] prod;
    int          dueCycle;
  } expItem_t;
  expItem_t sb[$];
  logic [31:0] lastHi = '0, lastLo = '0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cycle <= cycle + 1;

  shift_add_mul uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refProd(input logic [31:0] a, input logic [31:0] b,
                                          input bit sgn);
    logic [63:0] ea, eb;
    ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  // Driver: waits for an idle cycle (the done cycle counts), starts, records expectation.
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit sgn);
    expItem_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    opA = a; opB = b; signedMode = sgn; startPulse = 1'b1;
    it.prod = refProd(a, b, sgn);
    it.dueCycle = cycle + 34;
    sb.push_back(it);
    @(negedge clk);
    startPulse = 1'b0;
    check(busy === 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
    opA = ~a; opB = b ^ 32'h5A5A_0F0F; signedMode = ~sgn;  // operands must not matter now
  endtask

  // Start pulses while busy must be ignored (R7).
  task automatic pokeBusy(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) begin
        opA = 32'hDEAD_0000 + i; opB = 32'h0000_BEEF; startPulse = 1'b1;
        @(negedge clk);
        startPulse = 1'b0;
      end
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops on done, checks value, timing and result hold.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected done", {63'b0, done}, 64'd0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          check(cycle == it.dueCycle, "R3 done timing", 64'(cycle), 64'(it.dueCycle));
          check(busy === 1'b0, "R3 busy low with done", {63'b0, busy}, 64'd0);
          check(hiOut === it.prod[63:32], "R6 R4 R5 hiOut", {32'b0, hiOut},
                {32'b0, it.prod[63:32]});
          check(loOut === it.prod[31:0], "R6 R4 R5 loOut", {32'b0, loOut},
                {32'b0, it.prod[31:0]});
          lastHi = hiOut;
          lastLo = loOut;
        end
      end else if (busy) begin
        if (hiOut !== lastHi || loOut !== lastLo)
          check(1'b0, "R8 result held while busy", {hiOut, loOut}, {lastHi, lastLo});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {62'b0, busy, done}, 64'd0);
    check(hiOut === 32'd0 && loOut === 32'd0, "R1 reset result", {hiOut, loOut}, 64'd0);
    rstN = 1'b1;

    issue(32'd13, 32'd11, 1'b0);                   // R4 small
    waitIdle();
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);     // R4 max unsigned
    waitIdle();
    issue(32'hFFFF_FFFF, 32'd1, 1'b1);             // R5 -1 * 1
    waitIdle();
    issue(32'hFFFF_FFFC, 32'hFFFF_FFF9, 1'b1);     // R5 negative * negative
    waitIdle();
    issue(32'h1234_5678, 32'h8765_4321, 1'b1);     // R5 mixed signs
    waitIdle();
    issue(32'h8000_0000, 32'h8000_0000, 1'b1);     // R9 most negative squared
    waitIdle();
    issue(32'h8000_0000, 32'h0000_0003, 1'b1);     // R9 most negative * 3
    waitIdle();
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);     // R9 most negative * -1
    waitIdle();
    issue(32'd0, 32'hFFFF_FFFF, 1'b1);             // R9 zero signed
    waitIdle();
    issue(32'hDEAD_BEEF, 32'd0, 1'b0);             // R9 zero unsigned
    waitIdle();
    // R7: start pulses during a run
    issue(32'h0001_0003, 32'h7FFF_FFFF, 1'b0);
    pokeBusy(8);
    waitIdle();
    // R10: back-to-back, second start raised in the done cycle
    issue(32'hCAFE_F00D, 32'h0BAD_F00D, 1'b0);
    issue(32'h8000_0001, 32'h7FFF_FFFF, 1'b1);
    issue(32'h0000_0002, 32'hFFFF_FFFE, 1'b1);
    waitIdle();
    repeat (40) @(negedge clk);
    check(sb.size() == 0, "R7 no pending results", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule